// File: doc/BRIEF.md
# Host/Guest Filtered Event Counter Bank

This block holds a small set of performance event counters, each with its own select register. A select register carries an enable bit and a two-bit host/guest filter. The filter decides whether a pulse on the counter's event input is counted while the core runs a virtualized guest, while it runs the host, or in both cases. Filtering applies only while virtualization is switched on. With virtualization off, every enabled counter counts its events.

A core that takes a system-management interrupt from inside a guest, where the host does not intercept it, still reports guest context while it runs system-management code. A counter set to count only for the guest would then charge that code to the guest. To stop this, the bank can exchange the two filter bits of every select register when system-management mode is entered from guest mode. It exchanges them back on the matching resume. An input switches this correction on or off. An internal flag records whether an exchange took place, so only a guest-mode entry and its own resume cause exchanges.

Software writes select registers through a simple write port and reads them back through a registered read port. The counter values appear as registered outputs.

Top module: `hgc_bank`

## Requirements
- R1: While `rst` is high, every counter and every select register clears to 0, `rd_data` clears to 0, and the bank leaves system-management mode with no exchange pending.
- R2: When `wr_en` is 1 and `wr_idx` addresses an existing counter, `wr_data` is stored in that select register at the clock edge. After each edge `rd_data` holds the select register that `rd_idx` addressed before that edge, or 0 if `rd_idx` is out of range.
- R3: Bit 0 of a select register enables its counter. An enabled counter adds exactly one in each cycle where its event input is 1 and the filter permits counting. A disabled counter holds its value.
- R4: The filter sits in select bits 2:1. With `virt_en` at 1, the value 01 counts only while `guest_active` is 1, 10 counts only while `guest_active` is 0, and 00 or 11 count in both cases.
- R5: With `virt_en` at 0, every filter value permits counting.
- R6: A counter at its all-ones value returns to 0 on its next count.
- R7: When `smm_enter` arrives outside system-management mode while `swap_en`, `virt_en` and `guest_active` are all 1, bits 2 and 1 of every select register are exchanged at that edge.
- R8: The resume (`smm_resume` inside system-management mode) that follows an entry which exchanged the bits exchanges them again, restoring the original filters, whatever the value of `swap_en` at that time.
- R9: An entry with `virt_en` or `guest_active` at 0 exchanges nothing, and neither does the resume that follows it.
- R10: With `swap_en` at 0 at entry, nothing is exchanged on that entry or on its resume.
- R11: A write to a select register in the same cycle as an exchange stores `wr_data` unchanged. The other registers are exchanged.
- R12: `smm_enter` while already in system-management mode and `smm_resume` while outside it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| virt_en | input | 1 | Virtualization enabled; filtering is active only when 1 |
| guest_active | input | 1 | Core is running a guest |
| swap_en | input | 1 | Enables the filter exchange around system-management mode |
| smm_enter | input | 1 | Pulse: system-management mode is entered |
| smm_resume | input | 1 | Pulse: resume from system-management mode |
| event_in | input | NUM_CNT | One event pulse per counter |
| wr_en | input | 1 | Select register write strobe |
| wr_idx | input | IDX_W | Counter index for the write |
| wr_data | input | SEL_W | Select register write value |
| rd_idx | input | IDX_W | Counter index for the read-back |
| rd_data | output | SEL_W | Registered select register read-back |
| cnt_out | output | NUM_CNT*CNT_W | Counter values, counter i in bits [i*CNT_W +: CNT_W] |

## Verification
The bench builds the bank with six counters, a 4-bit counter width and an 8-bit select register. The narrow counters make wrap-around reachable within a few dozen counting cycles, and the 3-bit index leaves two out-of-range read addresses to exercise. The read index steps through every value on each cycle, so exchanged and restored filters can be seen at the ports. The stimulus includes guest-mode, host-mode and disabled-correction entries, repeated entry and resume pulses, and a write that lands in the same cycle as an exchange.

// File: rtl/hgc_pkg.sv
package hgc_pkg;

  typedef enum logic [1:0] {
    FLT_ALL_A  = 2'b00,
    FLT_GUEST  = 2'b01,
    FLT_HOST   = 2'b10,
    FLT_ALL_B  = 2'b11
  } hg_filt_e;

  function automatic logic filt_permit(input logic [1:0] filt,
                                       input logic virt_on,
                                       input logic in_guest);
    logic ok;
    if (!virt_on) begin
      ok = 1'b1;
    end else begin
      case (hg_filt_e'(filt))
        FLT_GUEST: ok = in_guest;
        FLT_HOST:  ok = !in_guest;
        default:   ok = 1'b1;
      endcase
    end
    return ok;
  endfunction

endpackage

// File: rtl/hgc_mode_ctrl.sv
module hgc_mode_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic virt_en,
  input  logic guest_active,
  input  logic swap_en,
  input  logic smm_enter,
  input  logic smm_resume,
  output logic swap_o
);

  logic in_smm_q;
  logic swapped_q;
  logic enter_ok;
  logic resume_ok;
  logic guest_mode;

  assign guest_mode = virt_en && guest_active;
  assign enter_ok   = smm_enter && !in_smm_q;
  assign resume_ok  = smm_resume && in_smm_q;
  assign swap_o     = (enter_ok && swap_en && guest_mode) || (resume_ok && swapped_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_smm_q  <= 1'b0;
      swapped_q <= 1'b0;
    end else if (enter_ok) begin
      in_smm_q  <= 1'b1;
      swapped_q <= swap_en && guest_mode;
    end else if (resume_ok) begin
      in_smm_q  <= 1'b0;
      swapped_q <= 1'b0;
    end
  end

  // R9: host-mode entries never exchange
  a_r9_host_entry_no_swap: assert property (@(posedge clk) disable iff (rst)
    (enter_ok && !guest_mode) |-> !swap_o);

  // R10: correction disabled at entry
  a_r10_disabled_no_swap: assert property (@(posedge clk) disable iff (rst)
    (smm_enter && !in_smm_q && !swap_en) |-> !swap_o);

  // R12: resume outside SMM does nothing
  a_r12_idle_resume: assert property (@(posedge clk) disable iff (rst)
    (smm_resume && !in_smm_q && !smm_enter) |=> (in_smm_q == 1'b0) && !swapped_q);

  // R8: pending exchange only exists inside SMM
  a_r8_flag_in_smm: assert property (@(posedge clk) disable iff (rst)
    swapped_q |-> in_smm_q);

endmodule

// File: rtl/hgc_counter.sv
module hgc_counter
  import hgc_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int SEL_W   = 8,
  parameter int EN_BIT  = 0,
  parameter int FLT_LSB = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [SEL_W-1:0] wr_data,
  input  logic             swap,
  input  logic             event_i,
  input  logic             virt_en,
  input  logic             guest_active,
  output logic [SEL_W-1:0] sel_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int FLT_MSB = FLT_LSB + 1;

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_swapped;
  logic [CNT_W-1:0] cnt_q;
  logic             count_now;

  always_comb begin
    sel_swapped          = sel_q;
    sel_swapped[FLT_LSB] = sel_q[FLT_MSB];
    sel_swapped[FLT_MSB] = sel_q[FLT_LSB];
  end

  assign count_now = event_i && sel_q[EN_BIT] &&
                     filt_permit(sel_q[FLT_MSB:FLT_LSB], virt_en, guest_active);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (wr_hit) begin
      sel_q <= wr_data;
    end else if (swap) begin
      sel_q <= sel_swapped;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (count_now) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign sel_o = sel_q;
  assign cnt_o = cnt_q;

  // R3: a counter never moves by anything other than one step
  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == $past(cnt_q)));

  // R3: disabled counter holds
  a_r3_disabled_holds: assert property (@(posedge clk) disable iff (rst)
    !sel_q[EN_BIT] |=> (cnt_q == $past(cnt_q)));

  // R11: a write wins over an exchange
  a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (sel_q == $past(wr_data)));

  // R7: an exchange trades the two filter bits
  a_r7_exchange: assert property (@(posedge clk) disable iff (rst)
    (swap && !wr_hit) |=> (sel_q[FLT_LSB] == $past(sel_q[FLT_MSB])) &&
                          (sel_q[FLT_MSB] == $past(sel_q[FLT_LSB])));

endmodule

// File: rtl/hgc_bank.sv
module hgc_bank #(
  parameter int NUM_CNT = 6,
  parameter int CNT_W   = 48,
  parameter int SEL_W   = 8,
  parameter int EN_BIT  = 0,
  parameter int FLT_LSB = 1,
  parameter int IDX_W   = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     virt_en,
  input  logic                     guest_active,
  input  logic                     swap_en,
  input  logic                     smm_enter,
  input  logic                     smm_resume,
  input  logic [NUM_CNT-1:0]       event_in,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [SEL_W-1:0]         wr_data,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic [SEL_W-1:0]         rd_data,
  output logic [NUM_CNT*CNT_W-1:0] cnt_out
);

  logic             swap_pulse;
  logic [SEL_W-1:0] sel_arr [NUM_CNT];
  logic [SEL_W-1:0] rd_q;

  hgc_mode_ctrl u_mode (
    .clk          (clk),
    .rst          (rst),
    .virt_en      (virt_en),
    .guest_active (guest_active),
    .swap_en      (swap_en),
    .smm_enter    (smm_enter),
    .smm_resume   (smm_resume),
    .swap_o       (swap_pulse)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(i));
    hgc_counter #(
      .CNT_W   (CNT_W),
      .SEL_W   (SEL_W),
      .EN_BIT  (EN_BIT),
      .FLT_LSB (FLT_LSB)
    ) u_cnt (
      .clk          (clk),
      .rst          (rst),
      .wr_hit       (hit),
      .wr_data      (wr_data),
      .swap         (swap_pulse),
      .event_i      (event_in[i]),
      .virt_en      (virt_en),
      .guest_active (guest_active),
      .sel_o        (sel_arr[i]),
      .cnt_o        (cnt_out[i*CNT_W +: CNT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (32'(rd_idx) < NUM_CNT) begin
      rd_q <= sel_arr[rd_idx];
    end else begin
      rd_q <= '0;
    end
  end

  assign rd_data = rd_q;

  // R2: out-of-range reads return zero
  a_r2_range_read: assert property (@(posedge clk) disable iff (rst)
    (32'(rd_idx) >= NUM_CNT) |=> (rd_data == '0));

endmodule

// File: tb/tb_hgc_bank.sv
`timescale 1ns/1ps
module tb_hgc_bank;

  localparam int NC = 6;
  localparam int CW = 4;
  localparam int SW = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst, virt_en, guest_active, swap_en, smm_enter, smm_resume, wr_en;
  logic [NC-1:0] event_in;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [SW-1:0] wr_data, rd_data;
  logic [NC*CW-1:0] cnt_out;

  always #2 clk = ~clk;

  hgc_bank #(.NUM_CNT(NC), .CNT_W(CW), .SEL_W(SW), .EN_BIT(0), .FLT_LSB(1)) dut (
    .clk(clk), .rst(rst), .virt_en(virt_en), .guest_active(guest_active),
    .swap_en(swap_en), .smm_enter(smm_enter), .smm_resume(smm_resume),
    .event_in(event_in), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .cnt_out(cnt_out));

  // reference model state
  logic [SW-1:0] m_sel [NC];
  logic [CW-1:0] m_cnt [NC];
  logic [SW-1:0] m_rd;
  logic m_in, m_sw;

  logic [NC*CW-1:0] q_cnt [$];
  logic [SW-1:0]    q_rd  [$];
  string            q_tag [$];

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;

  function automatic logic permit(logic [1:0] f, logic ve, logic ga);
    if (!ve) return 1'b1;
    if (f == 2'b01) return ga;
    if (f == 2'b10) return !ga;
    return 1'b1;
  endfunction

  // driver: compute expected state after next edge, push it, advance
  task automatic step(input string tag);
    logic do_sw, ent, res, g;
    logic [NC*CW-1:0] e;
    if (rst) begin
      for (int i = 0; i < NC; i++) begin m_sel[i] = '0; m_cnt[i] = '0; end
      m_rd = '0; m_in = 1'b0; m_sw = 1'b0;
    end else begin
      g   = virt_en && guest_active;
      ent = smm_enter && !m_in;
      res = smm_resume && m_in;
      do_sw = (ent && swap_en && g) || (res && m_sw);
      m_rd = (rd_idx < NC) ? m_sel[rd_idx] : '0;
      for (int i = 0; i < NC; i++) begin
        if (event_in[i] && m_sel[i][0] && permit(m_sel[i][2:1], virt_en, guest_active))
          m_cnt[i] = m_cnt[i] + 1'b1;
        if (wr_en && wr_idx == IW'(i)) m_sel[i] = wr_data;
        else if (do_sw) m_sel[i] = {m_sel[i][SW-1:3], m_sel[i][1], m_sel[i][2], m_sel[i][0]};
      end
      if (ent) begin m_in = 1'b1; m_sw = swap_en && g; end
      else if (res) begin m_in = 1'b0; m_sw = 1'b0; end
    end
    for (int i = 0; i < NC; i++) e[i*CW +: CW] = m_cnt[i];
    q_cnt.push_back(e);
    q_rd.push_back(m_rd);
    q_tag.push_back(tag);
    @(negedge clk);
    cyc++;
    rd_idx = IW'(cyc % 8);
    smm_enter = 1'b0;
    smm_resume = 1'b0;
    wr_en = 1'b0;
  endtask

  // monitor: compare away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_cnt.size() > 0) begin
        logic [NC*CW-1:0] e;
        logic [SW-1:0] r;
        string t;
        e = q_cnt.pop_front(); r = q_rd.pop_front(); t = q_tag.pop_front();
        for (int i = 0; i < NC; i++) begin
          vectors++;
          if (cnt_out[i*CW +: CW] !== e[i*CW +: CW]) begin
            errors++;
            $display("FAIL %s cnt%0d actual=%0d expected=%0d", t, i, cnt_out[i*CW +: CW], e[i*CW +: CW]);
          end
        end
        vectors++;
        if (rd_data !== r) begin
          errors++;
          $display("FAIL %s rd_data actual=%h expected=%h", t, rd_data, r);
        end
      end
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  task automatic wr(input int idx, input logic [SW-1:0] d, input string tag);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_data = d;
    step(tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  initial begin
    rst = 1'b1; virt_en = 0; guest_active = 0; swap_en = 0; smm_enter = 0;
    smm_resume = 0; wr_en = 0; wr_idx = 0; wr_data = 0; rd_idx = 0; event_in = '0;
    @(negedge clk);
    run(2, "R1 reset");
    rst = 1'b0;
    run(1, "R1 after reset");
    // filters: 0 guest, 1 host, 2 any00, 3 any11, 4 disabled, 5 guest
    wr(0, 8'h03, "R2 write"); wr(1, 8'h05, "R2 write"); wr(2, 8'h01, "R2 write");
    wr(3, 8'h07, "R2 write"); wr(4, 8'h00, "R2 write"); wr(5, 8'h03, "R2 write");
    run(8, "R2 readback");
    event_in = '1; virt_en = 1; guest_active = 1;
    run(3, "R4 guest mode");
    event_in = 6'b010101;
    run(2, "R3 partial events");
    event_in = '1; guest_active = 0;
    run(3, "R4 host mode");
    virt_en = 0;
    run(3, "R5 virt off");
    run(18, "R6 wrap");
    // guest-mode entry with correction
    virt_en = 1; guest_active = 1; swap_en = 1; smm_enter = 1;
    step("R7 enter from guest");
    run(8, "R7 in smm swapped");
    swap_en = 0; smm_resume = 1;
    step("R8 resume restores");
    run(8, "R8 after resume");
    // host-mode entry
    swap_en = 1; guest_active = 0; smm_enter = 1;
    step("R9 host entry");
    guest_active = 1;
    run(4, "R9 in smm");
    smm_resume = 1;
    step("R9 resume");
    run(8, "R9 after");
    // correction disabled
    swap_en = 0; smm_enter = 1;
    step("R10 entry");
    run(4, "R10 in smm");
    smm_resume = 1;
    step("R10 resume");
    run(8, "R10 after");
    // write collides with exchange
    swap_en = 1; smm_enter = 1; wr_en = 1; wr_idx = 1; wr_data = 8'h03;
    step("R11 write with swap");
    run(8, "R11 readback");
    smm_resume = 1;
    step("R11 resume");
    run(8, "R11 after");
    // repeated pulses
    smm_enter = 1;
    step("R12 first enter");
    smm_enter = 1;
    step("R12 second enter");
    run(3, "R12 in smm");
    smm_resume = 1;
    step("R12 resume");
    smm_resume = 1;
    step("R12 stray resume");
    run(8, "R12 after");
    event_in = '0;
    run(3, "R3 idle");
    @(posedge clk); #2;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule